// File: doc/BRIEF.md
# Symbol Duration Capture FIFO

This block times the symbols of a serial data stream that has already been demodulated. Time is counted in receive-clock ticks, and each tick arrives as a single-cycle enable. When a symbol ends, the block writes one entry into a small FIFO. The entry holds the symbol's duration in coarse units, which are the counter with its low bits dropped, together with the logic level the symbol had. Software later reads the entries and decodes the pulse train.

Two measurement modes are available. In period mode, a symbol runs from one rising edge to the next. In phase mode, every rising edge and every falling edge closes a symbol. If the line stays quiet long enough for the counter to saturate, the block writes a single all-ones marker entry and raises a timeout status. Each read returns the head entry plus a more-data bit that is worked out at the moment of the read. An interrupt can be set to fire either when the FIFO is not empty or when it is at least half full.

Top module: `symdur_capture`

## Requirements
- R1: The input level is sampled only on cycles where `rx_tick` is high, and level changes between ticks have no effect. A counter of DUR_W+LSB_DROP bits is cleared by reset. On every tick that closes a symbol it reloads to 1. On every other tick it adds 1 until it reaches its maximum, where it stays.
- R2: With `mode_phase` = 0 (period mode), only a tick whose sampled level is 1 while the previous sampled level was 0 closes a symbol. The stored level bit is therefore 0.
- R3: With `mode_phase` = 1 (phase mode), any tick whose sampled level differs from the previous sampled level closes a symbol. The entry stores the counter bits above the LSB_DROP low bits in entry bits [DUR_W-1:0], and the previous sampled level in bit DUR_W.
- R4: Consider a tick that does not close a symbol and finds the counter at its maximum. If the timeout is not yet flagged, that tick writes one entry with all DUR_W+1 bits set and sets `timeout_flag`. No further marker is written until a symbol-closing tick, which also clears `timeout_flag`.
- R5: The FIFO holds DEPTH entries and returns them in write order. `fifo_count`, `fifo_empty` and `fifo_full` track its occupancy. A read and a write in the same cycle are both accepted, even when the FIFO is full.
- R6: While `rd_en` is high and the FIFO is not empty, `rd_word[DUR_W:0]` carries the head entry. `rd_word[DUR_W+1]` is 1 only when more than one entry is stored at that moment. The entry is removed at the next clock edge.
- R7: A read from an empty FIFO returns all zeros and leaves the occupancy unchanged.
- R8: An entry that arrives when the FIFO is full, in a cycle with no read, is discarded. It also sets `overrun_flag`, which stays set until reset.
- R9: With `irq_half_sel` = 0, `rx_irq` equals "FIFO not empty". With `irq_half_sel` = 1, it equals "count is at least DEPTH/2".
- R10: After reset the FIFO is empty and `rx_irq`, `timeout_flag`, `overrun_flag` and `rd_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Receive clock enable, one cycle per tick |
| rx_level | input | 1 | Demodulated data level |
| mode_phase | input | 1 | 0 = period measurement, 1 = phase measurement |
| irq_half_sel | input | 1 | 0 = interrupt on not empty, 1 = interrupt on half full or more |
| rd_en | input | 1 | Read strobe, pops the head entry |
| rd_word | output | DUR_W+2 | Read data: more-data bit, level bit, duration |
| fifo_count | output | clog2(DEPTH+1) | Number of stored entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| timeout_flag | output | 1 | Idle timeout marker has been written |
| overrun_flag | output | 1 | Sticky: an entry was dropped |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench goes after four kinds of failure:
- Glitches placed between ticks. A design that sampled the level on every clock would log spurious short symbols.
- Idle stretches of more than a thousand ticks. A counter that wrapped instead of saturating would emit bogus durations, and one that did not latch the timeout would flood the FIFO with markers. The check for exactly one marker guards against both.
- Pushing past the full point, where an overwriting design would lose the oldest entries. Alongside this, a read that coincides with a write on a single-entry FIFO must show the more-data bit low.
- Period mode, where a design that also closed symbols on falling edges would produce twice the expected entries.

// File: rtl/symdur_pkg.sv
package symdur_pkg;

    typedef enum logic {
        MEAS_PERIOD = 1'b0,
        MEAS_PHASE  = 1'b1
    } meas_mode_e;

    typedef enum logic {
        IRQ_NOT_EMPTY = 1'b0,
        IRQ_HALF      = 1'b1
    } irq_sel_e;

    // Decide whether a sampled level change closes the current symbol
    function automatic logic ends_symbol(meas_mode_e mode, logic prev, logic cur);
        if (mode == MEAS_PHASE)
            return prev != cur;
        else
            return cur & ~prev;
    endfunction

endpackage

// File: rtl/symdur_meter.sv
module symdur_meter
    import symdur_pkg::*;
#(
    parameter int DUR_W    = 16,
    parameter int LSB_DROP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             level,
    input  logic             mode_phase,
    output logic             push,
    output logic [DUR_W:0]   push_data,
    output logic             timed_out
);
    localparam int CNT_W = DUR_W + LSB_DROP;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             prev_lvl;
    logic             to_q;
    logic             end_edge;
    logic             sat;
    logic             to_fire;

    always_comb begin
        end_edge  = tick && ends_symbol(meas_mode_e'(mode_phase), prev_lvl, level);
        sat       = (cnt == CNT_MAX);
        to_fire   = tick && !end_edge && sat && !to_q;
        push      = end_edge || to_fire;
        push_data = to_fire ? '1 : {prev_lvl, cnt[CNT_W-1:LSB_DROP]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            prev_lvl <= 1'b0;
            to_q     <= 1'b0;
        end else if (tick) begin
            prev_lvl <= level;
            if (end_edge) begin
                cnt  <= CNT_W'(1);
                to_q <= 1'b0;
            end else begin
                if (!sat)
                    cnt <= cnt + 1'b1;
                if (to_fire)
                    to_q <= 1'b1;
            end
        end
    end

    assign timed_out = to_q;

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt) && $stable(prev_lvl));
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick && !end_edge && !sat |=> cnt == $past(cnt) + 1'b1);
    // R1
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        end_edge |=> cnt == CNT_W'(1) && !timed_out);
    // R4
    timeout_set_chk: assert property (@(posedge clk) disable iff (rst)
        tick && sat && !end_edge |=> timed_out && cnt == CNT_MAX);

endmodule

// File: rtl/symdur_fifo.sv
module symdur_fifo #(
    parameter int WIDTH = 17,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         rd,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full,
    output logic                         overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    cnt_q;
    logic             pop;
    logic             accept;
    logic             ovr_q;

    always_comb begin
        pop    = rd && (cnt_q != '0);
        accept = wr && ((cnt_q != CW'(DEPTH)) || pop);
    end

    always_ff @(posedge clk) begin
        if (accept)
            mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (accept)
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (accept && !pop)
                cnt_q <= cnt_q + 1'b1;
            else if (pop && !accept)
                cnt_q <= cnt_q - 1'b1;
            if (wr && !accept)
                ovr_q <= 1'b1;
        end
    end

    assign head    = mem[rptr];
    assign count   = cnt_q;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign overrun = ovr_q;

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    // R5
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr && !rd && !full |=> count == $past(count) + 1'b1);
    // R8
    overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr && !rd && full |=> overrun && full);
    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd && empty && !wr |=> empty);

endmodule

// File: rtl/symdur_capture.sv
module symdur_capture
    import symdur_pkg::*;
#(
    parameter int DUR_W    = 16,
    parameter int LSB_DROP = 4,
    parameter int DEPTH    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rx_tick,
    input  logic                         rx_level,
    input  logic                         mode_phase,
    input  logic                         irq_half_sel,
    input  logic                         rd_en,
    output logic [DUR_W+1:0]             rd_word,
    output logic [$clog2(DEPTH+1)-1:0]   fifo_count,
    output logic                         fifo_empty,
    output logic                         fifo_full,
    output logic                         timeout_flag,
    output logic                         overrun_flag,
    output logic                         rx_irq
);
    localparam int EW = DUR_W + 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          push;
    logic [EW-1:0] push_data;
    logic [EW-1:0] head;

    symdur_meter #(.DUR_W(DUR_W), .LSB_DROP(LSB_DROP)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .tick       (rx_tick),
        .level      (rx_level),
        .mode_phase (mode_phase),
        .push       (push),
        .push_data  (push_data),
        .timed_out  (timeout_flag)
    );

    symdur_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr      (push),
        .wdata   (push_data),
        .rd      (rd_en),
        .head    (head),
        .count   (fifo_count),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .overrun (overrun_flag)
    );

    // More-data bit is formed at read time from the live occupancy
    always_comb begin
        if (rd_en && !fifo_empty)
            rd_word = {(fifo_count > CW'(1)), head};
        else
            rd_word = '0;
    end

    always_comb begin
        if (irq_sel_e'(irq_half_sel) == IRQ_HALF)
            rx_irq = (fifo_count >= CW'(DEPTH / 2));
        else
            rx_irq = !fifo_empty;
    end

    // R9
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_half_sel |-> rx_irq == !fifo_empty);
    // R6
    last_entry_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && fifo_count == CW'(1) |-> !rd_word[DUR_W+1]);
    // R7
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && fifo_empty |-> rd_word == '0);
    // R6
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && !fifo_empty && !push |=> fifo_count == $past(fifo_count) - 1'b1);

endmodule

// File: tb/symdur_capture_test.sv
`timescale 1ns/1ps
module symdur_capture_test;
    localparam int DW   = 8;
    localparam int LD   = 2;
    localparam int DEP  = 16;
    localparam int EW   = DW + 1;
    localparam int CW   = $clog2(DEP + 1);
    localparam int DMAX = (1 << (DW + LD)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_tick = 1'b0;
    logic rx_level = 1'b0;
    logic mode_phase = 1'b1;
    logic irq_half_sel = 1'b0;
    logic rd_en = 1'b0;
    logic [DW+1:0] rd_word;
    logic [CW-1:0] fifo_count;
    logic fifo_empty, fifo_full, timeout_flag, overrun_flag, rx_irq;

    symdur_capture #(.DUR_W(DW), .LSB_DROP(LD), .DEPTH(DEP)) uut (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_level(rx_level),
        .mode_phase(mode_phase), .irq_half_sel(irq_half_sel), .rd_en(rd_en),
        .rd_word(rd_word), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .timeout_flag(timeout_flag),
        .overrun_flag(overrun_flag), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    logic [EW-1:0] exp_q[$];
    int   m_d = 0;
    logic m_prev = 1'b0;
    logic m_to = 1'b0;
    logic m_ovr = 1'b0;

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic push_exp(input logic [EW-1:0] e);
        if (exp_q.size() < DEP) exp_q.push_back(e);
        else m_ovr = 1'b1;
    endtask

    // Driver and scoreboard: drive one cycle, compare a read, update expectation
    task automatic step(input logic lvl, input logic tk, input logic rd, input string req);
        logic endk;
        @(negedge clk);
        rx_level = lvl;
        rx_tick  = tk;
        rd_en    = rd;
        #1;
        if (rd) begin
            if (exp_q.size() == 0) begin
                check_eq("R7", "empty read word", rd_word, 0);
            end else begin
                check_eq(req, "read entry", rd_word[EW-1:0], exp_q[0]);
                check_eq("R6", "more-data bit", rd_word[EW], exp_q.size() > 1);
            end
        end
        @(posedge clk);
        #1;
        rx_tick = 1'b0;
        rd_en   = 1'b0;
        if (rd && exp_q.size() > 0) void'(exp_q.pop_front());
        if (tk) begin
            endk = mode_phase ? (lvl != m_prev) : (lvl && !m_prev);
            if (endk) begin
                push_exp({m_prev, DW'(m_d >> LD)});
                m_d  = 1;
                m_to = 1'b0;
            end else if (m_d == DMAX) begin
                if (!m_to) begin
                    push_exp('1);
                    m_to = 1'b1;
                end
            end else begin
                m_d++;
            end
            m_prev = lvl;
        end
    endtask

    // n ticks at a level, each followed by an ignored opposite-level glitch
    task automatic hold(input logic lvl, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(lvl, 1'b1, 1'b0, req);
            step(~lvl, 1'b0, 1'b0, req);
        end
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) step(rx_level, 1'b0, 1'b1, req);
    endtask

    task automatic status(input string req);
        check_eq(req, "fifo_count", fifo_count, exp_q.size());
        check_eq(req, "fifo_empty", fifo_empty, exp_q.size() == 0);
        check_eq(req, "fifo_full", fifo_full, exp_q.size() == DEP);
        check_eq("R9", "rx_irq", rx_irq,
                 irq_half_sel ? (exp_q.size() >= DEP / 2) : (exp_q.size() != 0));
        check_eq("R4", "timeout_flag", timeout_flag, m_to);
        check_eq("R8", "overrun_flag", overrun_flag, m_ovr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        logic lv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check_eq("R10", "count after reset", fifo_count, 0);
        check_eq("R10", "empty after reset", fifo_empty, 1);
        check_eq("R10", "irq after reset", rx_irq, 0);
        check_eq("R10", "timeout after reset", timeout_flag, 0);
        check_eq("R10", "overrun after reset", overrun_flag, 0);
        check_eq("R10", "rd_word after reset", rd_word, 0);

        // R1: phase mode with glitches between ticks
        mode_phase = 1'b1;
        hold(1'b1, 20, "R1");
        hold(1'b0, 37, "R1");
        hold(1'b1, 64, "R1");
        hold(1'b0, 5, "R1");
        status("R1");
        drain("R1");

        // R2: period mode, only rising edges close symbols
        mode_phase = 1'b0;
        hold(1'b1, 30, "R2");
        hold(1'b0, 50, "R2");
        hold(1'b1, 10, "R2");
        hold(1'b0, 10, "R2");
        hold(1'b1, 3, "R2");
        status("R2");
        drain("R2");

        // R3: phase mode durations and levels
        mode_phase = 1'b1;
        hold(1'b0, 100, "R3");
        hold(1'b1, 13, "R3");
        hold(1'b0, 7, "R3");
        hold(1'b1, 200, "R3");
        hold(1'b0, 1, "R3");
        status("R3");
        drain("R3");

        // R9: half-full interrupt threshold
        irq_half_sel = 1'b1;
        for (int i = 0; i < 9; i++) begin
            hold(~m_prev, 4, "R9");
            status("R9");
        end
        drain("R9");
        status("R9");

        // R5 / R8: fill past full without reading
        irq_half_sel = 1'b0;
        for (int i = 0; i < 20; i++) hold(~m_prev, 3, "R5");
        status("R8");
        drain("R5");
        status("R5");

        // R7: read from empty FIFO
        step(rx_level, 1'b0, 1'b1, "R7");
        status("R7");

        // R6: read of the only entry while a new one is written
        hold(~m_prev, 6, "R6");
        step(~m_prev, 1'b1, 1'b1, "R6");
        status("R6");
        drain("R6");

        // R4: idle timeout writes exactly one marker
        lv = ~m_prev;
        hold(lv, 3, "R4");
        hold(lv, DMAX + 80, "R4");
        status("R4");
        drain("R4");
        hold(~m_prev, 2, "R4");
        status("R4");
        drain("R4");

        finish_up();
    end

endmodule